// File: doc/BRIEF.md
# Host-side serial register access controller

This block is the master end of a four-wire, externally clocked serial link to a converter-style peripheral. The peripheral holds an output data word, a control register and a calibration register, each 24 bits wide. Commands arrive over a valid/ready handshake. Each command names one of four operations and, for writes, carries a 24-bit payload. The controller generates the serial clock from a programmable divider. It drives the receive strobe, the transmit strobe and the register-select line. It also shifts the word across the link, most significant bit first.

Only an output-word read waits for the peripheral's active-low data-ready input. The other three operations start at once. A read returns its 24-bit result on a one-cycle response pulse. A write completes silently and frees the command port again after a short idle gap.

Top module: `serreg_host`

## Requirements
- R1: A command is accepted (`cmd_valid` and `cmd_ready` both high at a clock edge) only while the block is idle. `cmd_ready` stays low from acceptance until the frame and its trailing gap have finished.
- R2: Operation code 0 reads the output word. `rd_frame_n` does not fall while `dat_rdy_n` is high, and `reg_sel` is high for the whole frame.
- R3: Operation code 1 reads the control register. It starts regardless of `dat_rdy_n`, and `reg_sel` is low for the whole frame.
- R4: Operation code 2 writes the control register with `reg_sel` low, and code 3 writes the calibration register with `reg_sel` high. `wr_frame_n` is low for the frame, and `ser_out` carries `cmd_wdata` MSB first. `ser_out` is stable at every rising `sclk` edge.
- R5: A read samples `ser_in` on each falling `sclk` edge, MSB first. The 24-bit result appears on `rsp_rdata` with `rsp_valid` high for exactly one cycle, in the cycle that `rd_frame_n` returns high. Writes produce no response pulse.
- R6: `sclk` idles low and gives exactly 24 pulses per frame. Each high phase and each low phase between pulses lasts `div_half` clock cycles. A value of 0 is treated as 1, and the value is captured when the command is accepted.
- R7: The strobes change only while `sclk` is low and was low in the previous cycle. `reg_sel` does not change while a strobe is low, and it is high between frames.
- R8: `rd_frame_n` and `wr_frame_n` are never low at the same time.
- R9: At least two half-periods (one full idle `sclk` period) pass from a strobe returning high to the next frame's strobe falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | High while idle; command taken when both are high |
| cmd_op | input | 2 | 0 read output word, 1 read control, 2 write control, 3 write calibration |
| cmd_wdata | input | 24 | Write payload |
| div_half | input | 8 | Serial clock half-period in system clock cycles (0 acts as 1) |
| rsp_valid | output | 1 | One-cycle pulse when read data is ready |
| rsp_rdata | output | 24 | Read result |
| sclk | output | 1 | Serial clock, idles low |
| rd_frame_n | output | 1 | Active-low receive frame strobe |
| wr_frame_n | output | 1 | Active-low transmit frame strobe |
| reg_sel | output | 1 | Register select toward the peripheral |
| ser_out | output | 1 | Serial data to the peripheral |
| ser_in | input | 1 | Serial data from the peripheral |
| dat_rdy_n | input | 1 | Active-low data-ready from the peripheral |

## Verification
A wrong state in the sequencer shows up at the pins within one half-period. A strobe moving while `sclk` is high, a select line switching mid-frame, or both strobes low at once all appear that way. A bit counter that is off by one appears at the end of the frame as a pulse count other than 24, and as a shifted response word or a shifted register update in the peripheral model. A divider fault shows as a high or low phase whose width differs from `div_half`, and it is caught on the first pulse. The wrong select value for an operation surfaces at the end of the frame, because the model then returns or updates a different register than the bench expects.

// File: rtl/serreg_host.sv
module serreg_host #(
  parameter int DW   = 24,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic [DW-1:0]   cmd_wdata,
  input  logic [DIVW-1:0] div_half,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            sclk,
  output logic            rd_frame_n,
  output logic            wr_frame_n,
  output logic            reg_sel,
  output logic            ser_out,
  input  logic            ser_in,
  input  logic            dat_rdy_n
);
  localparam int BW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SETUP, S_SHIFT, S_HOLD, S_GAP} st_t;

  st_t             st;
  logic [1:0]      op_q;
  logic [DW-1:0]   sh;
  logic [DIVW-1:0] cnt, half_q;
  logic [BW-1:0]   nbit;
  logic            gap2, sclk_q, rsp_q;

  wire tick     = (cnt == half_q - 1'b1);
  wire is_rd    = ~op_q[1];
  wire in_frame = (st == S_SETUP) || (st == S_SHIFT) || (st == S_HOLD);

  assign cmd_ready  = (st == S_IDLE);
  assign sclk       = sclk_q;
  assign rd_frame_n = ~(in_frame & is_rd);
  assign wr_frame_n = ~(in_frame & ~is_rd);
  assign reg_sel    = in_frame ? ~(op_q[0] ^ op_q[1]) : 1'b1;
  assign ser_out    = (in_frame & ~is_rd) ? sh[DW-1] : 1'b0;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= '0;
      sh     <= '0;
      cnt    <= '0;
      half_q <= DIVW'(1);
      nbit   <= '0;
      gap2   <= 1'b0;
      sclk_q <= 1'b0;
      rsp_q  <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      if (st == S_IDLE || st == S_WAIT) cnt <= '0;
      else                              cnt <= tick ? '0 : cnt + 1'b1;
      unique case (st)
        S_IDLE: if (cmd_valid) begin
          op_q   <= cmd_op;
          sh     <= cmd_op[1] ? cmd_wdata : '0;
          half_q <= (div_half == '0) ? DIVW'(1) : div_half;
          nbit   <= '0;
          st     <= (cmd_op == 2'd0) ? S_WAIT : S_SETUP;
        end
        S_WAIT: if (!dat_rdy_n) st <= S_SETUP;
        S_SETUP: if (tick) begin
          sclk_q <= 1'b1;
          st     <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          sclk_q <= ~sclk_q;
          if (sclk_q) begin
            sh   <= {sh[DW-2:0], ser_in};
            nbit <= nbit + 1'b1;
            if (nbit == BW'(DW-1)) st <= S_HOLD;
          end
        end
        S_HOLD: if (tick) begin
          rsp_q <= is_rd;
          gap2  <= 1'b0;
          st    <= S_GAP;
        end
        S_GAP: if (tick) begin
          if (gap2) st <= S_IDLE;
          else      gap2 <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |-> rd_frame_n && wr_frame_n && !sclk); // R1
  AST_RDY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_frame_n) && reg_sel |-> !$past(dat_rdy_n)); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5
  AST_RSP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(rd_frame_n)); // R5
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_frame_n && wr_frame_n |-> !sclk); // R6
  AST_STROBE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_frame_n) || !$stable(wr_frame_n) |-> !sclk && !$past(sclk)); // R7
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rd_frame_n || !wr_frame_n) && (!rd_frame_n || !wr_frame_n) |-> $stable(reg_sel)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_frame_n && !wr_frame_n)); // R8
endmodule

// File: tb/serreg_host_tb.sv
`timescale 1ns/1ps
module serreg_host_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, ser_in = 1'b0, dat_rdy_n = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [23:0] cmd_wdata = '0;
  logic [7:0]  div_half = 8'd1;
  logic cmd_ready, rsp_valid, sclk, rd_frame_n, wr_frame_n, reg_sel, ser_out;
  logic [23:0] rsp_rdata;

  always #2.5 clk = ~clk;

  serreg_host u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .div_half(div_half),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sclk(sclk),
    .rd_frame_n(rd_frame_n), .wr_frame_n(wr_frame_n), .reg_sel(reg_sel),
    .ser_out(ser_out), .ser_in(ser_in), .dat_rdy_n(dat_rdy_n)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $realtime);
    end
  endtask

  // peripheral model
  logic [23:0] dev_out_word = 24'h5A3C96, dev_ctrl = '0, dev_cal = '0, dev_tx = '0, dev_rx = '0;
  logic fr_a0 = 1'b1;
  int   dev_bits = 0, fr_pulses = 0, cur_h = 1, prev_h = 1;
  bit   had_frame = 0;
  realtime t_rise = 0, t_fall = 0, t_up = 0;

  always @(negedge rd_frame_n or negedge wr_frame_n) begin
    fr_a0 = reg_sel; dev_bits = 0; fr_pulses = 0; dev_rx = '0;
    dev_tx = reg_sel ? dev_out_word : dev_ctrl;
    if (had_frame) chk(int'(($realtime - t_up) / 5.0) >= 2 * prev_h, "R9 gap",
                       int'(($realtime - t_up) / 5.0), 2 * prev_h);
  end

  always @(posedge rd_frame_n or posedge wr_frame_n) if (rst_n) begin
    if (!wr_frame_n || !rd_frame_n) ; else begin
      chk(fr_pulses == 24, "R6 pulse count", fr_pulses, 24);
      t_up = $realtime; had_frame = 1; prev_h = cur_h;
    end
  end

  always @(posedge wr_frame_n) if (rst_n && fr_pulses == 24) begin
    if (fr_a0) dev_cal = dev_rx; else dev_ctrl = dev_rx;
  end

  always @(rd_frame_n or wr_frame_n) if (rst_n) begin
    chk(!sclk, "R7 strobe edge with sclk low", sclk, 0);
    chk(rd_frame_n || wr_frame_n, "R8 strobe exclusion", {rd_frame_n, wr_frame_n}, 2'b11);
  end

  always @(posedge sclk) begin
    if (fr_pulses > 0)
      chk(int'(($realtime - t_fall) / 5.0) == cur_h, "R6 low phase", int'(($realtime - t_fall) / 5.0), cur_h);
    t_rise = $realtime;
    fr_pulses++;
    chk(reg_sel == fr_a0, "R7 select stable", reg_sel, fr_a0);
    chk(!rd_frame_n || !wr_frame_n, "R6 sclk only in frame", {rd_frame_n, wr_frame_n}, 0);
    if (!rd_frame_n) begin
      ser_in = dev_tx[23 - dev_bits];
      dev_bits++;
    end
    if (!wr_frame_n) dev_rx = {dev_rx[22:0], ser_out};
  end

  always @(negedge sclk) if (rst_n) begin
    t_fall = $realtime;
    chk(int'((t_fall - t_rise) / 5.0) == cur_h, "R6 high phase", int'((t_fall - t_rise) / 5.0), cur_h);
  end

  logic [23:0] exp_ctrl = '0, exp_cal = '0;

  task automatic issue(input logic [1:0] op, input logic [23:0] wd, input logic [7:0] h);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    div_half = h; cmd_op = op; cmd_wdata = wd; cmd_valid = 1'b1;
    cur_h = (h == 0) ? 1 : int'(h);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R1 busy after accept", cmd_ready, 0);
  endtask

  task automatic complete(input logic [1:0] op, input logic [23:0] wd);
    int n = 0;
    if (!op[1]) begin
      while (!rsp_valid && n < 20000) begin @(negedge clk); n++; end
      chk(rsp_rdata == ((op == 0) ? dev_out_word : exp_ctrl),
          (op == 0) ? "R2 output word read" : "R3 control read",
          rsp_rdata, (op == 0) ? dev_out_word : exp_ctrl);
      chk(rd_frame_n, "R5 response at strobe release", rd_frame_n, 1);
      @(negedge clk);
      chk(!rsp_valid, "R5 one-cycle pulse", rsp_valid, 0);
    end else begin
      while (!cmd_ready && n < 20000) begin
        @(negedge clk); n++;
        if (rsp_valid) chk(0, "R5 no response on write", 1, 0);
      end
      if (op == 2'd2) begin exp_ctrl = wd; chk(dev_ctrl == wd, "R4 control write", dev_ctrl, wd); end
      else            begin exp_cal  = wd; chk(dev_cal == wd, "R4 calibration write", dev_cal, wd); end
    end
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready, "R1 ready after reset", cmd_ready, 1);
    chk(!sclk && rd_frame_n && wr_frame_n, "R6 idle lines after reset", {sclk, rd_frame_n, wr_frame_n}, 3'b011);
    chk(reg_sel, "R7 select high when idle", reg_sel, 1);
    chk(!rsp_valid, "R5 no response after reset", rsp_valid, 0);

    // directed: control write, control read, calibration write
    issue(2'd2, 24'hA5F00F, 8'd1); complete(2'd2, 24'hA5F00F);
    issue(2'd1, 24'h0, 8'd0);      complete(2'd1, 24'h0);
    issue(2'd3, 24'h800001, 8'd3); complete(2'd3, 24'h800001);

    // directed: output read held off by data-ready
    dat_rdy_n = 1'b1;
    issue(2'd0, 24'h0, 8'd2);
    repeat (40) @(negedge clk);
    chk(rd_frame_n, "R2 read held while not ready", rd_frame_n, 1);
    chk(!sclk, "R2 no clock while waiting", sclk, 0);
    dev_out_word = 24'hFFFFFF;
    dat_rdy_n = 1'b0;
    complete(2'd0, 24'h0);

    // directed: control read ignores data-ready
    dat_rdy_n = 1'b1;
    issue(2'd1, 24'h0, 8'd2); complete(2'd1, 24'h0);
    dat_rdy_n = 1'b0;

    // directed: valid held during a busy frame is taken only after idle
    issue(2'd2, 24'h123456, 8'd1);
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_wdata = 24'h00FF00;
    repeat (10) @(negedge clk);
    chk(!cmd_ready && !wr_frame_n, "R1 no accept while busy", {cmd_ready, wr_frame_n}, 0);
    while (!cmd_ready) @(negedge clk);
    chk(dev_ctrl == 24'h123456, "R4 first write intact", dev_ctrl, 24'h123456);
    exp_ctrl = 24'h123456;
    @(negedge clk); cmd_valid = 1'b0;
    complete(2'd3, 24'h00FF00);

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [1:0]  op = 2'($urandom % 4);
      logic [23:0] wd = 24'($urandom);
      logic [7:0]  h  = 8'($urandom % 5);
      dev_out_word = 24'($urandom);
      dat_rdy_n = (op == 2'd1) ? 1'($urandom % 2) : 1'b0;
      issue(op, wd, h);
      complete(op, wd);
      dat_rdy_n = 1'b0;
    end
    chk(dev_cal == exp_cal, "R4 calibration retained", dev_cal, exp_cal);

    repeat (10) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule